// File: doc/BRIEF.md
# Pixel Clock Divider and Shift Clock Gate

This block runs entirely on the pixel clock. It derives three timing outputs for a video back end. The first is a pixel-load strobe. A single mode input sets its rate: either one strobe per pixel clock, or one strobe every second pixel clock for two-pixels-per-load operation. The second is a slower programmable clock for a controller or frame-buffer logic, at one quarter down to one thirty-second of the pixel rate. The third is a shift clock for video memory. It is the incoming shift clock passed through a synchronous gate that stops it whenever blanking is active, so memory does not advance during retrace.

Both divided outputs come from one shared phase counter. Each rising edge of the programmable clock therefore falls on a cycle where the load strobe also rises. Any change to the mode or the divide select restarts the counter on that same edge, so the two outputs stay aligned. All outputs are registered. A synchronous reset holds them low.

Top module: `pclk_ctrl`

## Requirements
- R1: With `half_rate` = 1 and no configuration change, `load_out` alternates every cycle. It is high in the first cycle after a restart and low in the next.
- R2: With `half_rate` = 0, `load_out` is high in every cycle outside reset, acting as a per-cycle enable.
- R3: `half_rate` alone selects the load strobe rate: 1 selects half the pixel rate and 0 selects the full pixel rate.
- R4: `prg_out` never rises in a cycle where `load_out` is low.
- R5: `prg_out` has a period of 4, 8, 16 or 32 cycles for `div_sel` = 00, 01, 10 or 11 respectively. It has a 50% duty cycle and is high for the first half of each period counted from a restart.
- R6: `shift_out` equals `shift_in AND NOT blank` as sampled one clock earlier. It is low during blanking.
- R7: On any clock edge where `half_rate` or `div_sel` differs from its value at the previous edge, both divided outputs restart at phase 0, which makes both of them high.
- R8: While `rst` is high at a clock edge, all three outputs are low after that edge. The first edge with `rst` low starts phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| half_rate | input | 1 | Load strobe rate: 1 = half pixel rate, 0 = full pixel rate |
| div_sel | input | 2 | Programmable clock divide select (00 /4, 01 /8, 10 /16, 11 /32) |
| shift_in | input | 1 | Incoming video memory shift clock |
| blank | input | 1 | Blanking active (high during retrace) |
| load_out | output | 1 | Pixel load strobe |
| prg_out | output | 1 | Programmable divided clock |
| shift_out | output | 1 | Blank-gated shift clock |

## Verification
A wrong phase counter value shows up at `prg_out` within half a divide period, and at `load_out` on the next cycle in half-rate mode. This happens because both outputs decode the same count. A missed or spurious restart shows at the next edge as outputs that are not both high. From then on, every cycle compares out of step with a reference that keeps its own phase integer. A fault in the shift gate shows one cycle after the offending `blank` value. Blank and shift inputs are driven from a pseudo-random sequence so that every combination occurs.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  // log2 of the smallest division ratio of the programmable clock
  localparam int MIN_DIV_LOG2 = 2;
  // width of the divide select
  localparam int SEL_W = 2;
  // counter width covering the largest division ratio
  localparam int PHASE_W = MIN_DIV_LOG2 + (1 << SEL_W) - 1;

  typedef struct packed {
    logic             half;
    logic [SEL_W-1:0] sel;
  } clk_cfg_t;
endpackage

// File: rtl/pclk_cfg_track.sv
module pclk_cfg_track
  import pclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  clk_cfg_t cfg_in,
  output clk_cfg_t cfg_q,
  output logic     restart
);
  // Tracks the configuration applied at the previous edge. It also loads
  // during reset, so that leaving reset alone causes no restart.
  always_ff @(posedge clk) begin
    cfg_q <= cfg_in;
  end

  assign restart = !rst && (cfg_in != cfg_q);
endmodule

// File: rtl/pclk_phase_ctr.sv
module pclk_phase_ctr #(
  parameter int PHASE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  output logic [PHASE_W-1:0] phase_nxt,
  output logic [PHASE_W-1:0] phase_q
);
  // Reset parks the count at all-ones, so the first edge out of reset gives 0.
  always_comb begin
    if (restart) phase_nxt = '0;
    else         phase_nxt = phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '1;
    else     phase_q <= phase_nxt;
  end

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !restart |=> (phase_q == PHASE_W'($past(phase_q) + 1'b1))) else $error("phase skipped"); // R5
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase_q == '0)) else $error("restart not at phase 0"); // R7
endmodule

// File: rtl/pclk_strobe_gen.sv
module pclk_strobe_gen
  import pclk_pkg::*;
#(
  parameter int PW = PHASE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  clk_cfg_t      cfg_in,
  input  logic [PW-1:0] phase_nxt,
  output logic          load_out,
  output logic          prg_out
);
  localparam int NUM_DIV = 1 << SEL_W;

  // One candidate level per divide ratio. Each is high in the first half of its period.
  logic [NUM_DIV-1:0] prg_tap;

  genvar g;
  generate
    for (g = 0; g < NUM_DIV; g++) begin : g_tap
      assign prg_tap[g] = ~phase_nxt[MIN_DIV_LOG2 - 1 + g];
    end
  endgenerate

  logic load_nxt;
  assign load_nxt = cfg_in.half ? ~phase_nxt[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_out <= 1'b0;
      prg_out  <= 1'b0;
    end else begin
      load_out <= load_nxt;
      prg_out  <= prg_tap[cfg_in.sel];
    end
  end
endmodule

// File: rtl/pclk_shift_gate.sv
module pclk_shift_gate (
  input  logic clk,
  input  logic rst,
  input  logic shift_in,
  input  logic blank,
  output logic shift_out
);
  always_ff @(posedge clk) begin
    if (rst) shift_out <= 1'b0;
    else     shift_out <= shift_in & ~blank;
  end

  AST_BLANK_STOPS_SHIFT: assert property (@(posedge clk) disable iff (rst)
    $past(blank) |-> !shift_out) else $error("shift during blank"); // R6
endmodule

// File: rtl/pclk_ctrl.sv
module pclk_ctrl
  import pclk_pkg::*;
#(
  parameter int PW = PHASE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_rate,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             shift_in,
  input  logic             blank,
  output logic             load_out,
  output logic             prg_out,
  output logic             shift_out
);
  clk_cfg_t      cfg_now;
  clk_cfg_t      cfg_q;
  logic          restart;
  logic [PW-1:0] phase_nxt;
  logic [PW-1:0] phase_q;

  assign cfg_now.half = half_rate;
  assign cfg_now.sel  = div_sel;

  pclk_cfg_track u_cfg (
    .clk(clk), .rst(rst), .cfg_in(cfg_now), .cfg_q(cfg_q), .restart(restart)
  );

  pclk_phase_ctr #(.PHASE_W(PW)) u_phase (
    .clk(clk), .rst(rst), .restart(restart),
    .phase_nxt(phase_nxt), .phase_q(phase_q)
  );

  pclk_strobe_gen #(.PW(PW)) u_strobe (
    .clk(clk), .rst(rst), .cfg_in(cfg_now), .phase_nxt(phase_nxt),
    .load_out(load_out), .prg_out(prg_out)
  );

  pclk_shift_gate u_shift (
    .clk(clk), .rst(rst), .shift_in(shift_in), .blank(blank),
    .shift_out(shift_out)
  );

  // High once the outputs come from an edge that was not in reset.
  logic run_q;
  always_ff @(posedge clk) begin
    run_q <= !rst;
  end

  AST_PRG_RISE_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (run_q && $rose(prg_out)) |-> load_out) else $error("prg rose without load"); // R4
  AST_FULL_RATE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (run_q && !cfg_q.half) |-> load_out) else $error("load dropped at full rate"); // R2
  AST_HALF_RATE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (run_q && cfg_q.half && !restart) |=> (load_out != $past(load_out))) else $error("load did not toggle"); // R1
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!load_out && !prg_out && !shift_out)) else $error("output high in reset"); // R8
endmodule

// File: tb/pclk_ctrl_tb_top.sv
module pclk_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       half_rate = 1'b1;
  logic [1:0] div_sel = 2'b00;
  logic       shift_in = 1'b0;
  logic       blank = 1'b0;
  logic       load_out, prg_out, shift_out;

  always #5 clk = ~clk;

  pclk_ctrl dut_i (
    .clk(clk), .rst(rst), .half_rate(half_rate), .div_sel(div_sel),
    .shift_in(shift_in), .blank(blank),
    .load_out(load_out), .prg_out(prg_out), .shift_out(shift_out)
  );

  int         n_chk = 0;
  int         n_fail = 0;
  int         ph = 31;
  logic [2:0] prev_cfg = 3'b000;
  logic       prev_prg = 1'b0;
  logic       was_rst = 1'b1;
  logic [7:0] lfsr = 8'hA5;
  bit         done = 1'b0;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: an integer phase that advances per edge and is zeroed on any configuration change.
  task automatic cyc(input logic r, input logic h, input logic [1:0] s);
    @(negedge clk);
    begin
      logic [2:0] cur;
      int n;
      logic e_load, e_prg, e_shift;
      bit restarted;
      string lt, pt;
      cur = {half_rate, div_sel};
      restarted = 1'b0;
      if (rst) begin
        ph = 31;
        e_load = 0; e_prg = 0; e_shift = 0;
        lt = "R8"; pt = "R8";
      end else begin
        if (cur != prev_cfg) begin ph = 0; restarted = 1'b1; end
        else ph = (ph + 1) % 32;
        n = 4 << div_sel;
        e_load = half_rate ? ((ph % 2) == 0) : 1'b1;
        e_prg = (ph % n) < (n / 2);
        e_shift = shift_in & ~blank;
        lt = half_rate ? "R1 R3" : "R2 R3";
        pt = "R5";
        if (restarted) begin lt = "R7"; pt = "R7"; end
        if (was_rst)   begin lt = "R8"; pt = "R8"; end
      end
      prev_cfg = cur;
      chk(lt, load_out, e_load);
      chk(pt, prg_out, e_prg);
      chk(rst ? "R8" : "R6", shift_out, e_shift);
      if (!rst && prg_out && !prev_prg) chk("R4", load_out, 1'b1);
      prev_prg = prg_out;
      was_rst = rst;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rst = r; half_rate = h; div_sel = s;
    shift_in = lfsr[0]; blank = lfsr[3] & lfsr[6];
  endtask

  initial begin
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 2'b00);
    // half rate, every divide ratio
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 70; i++) cyc(1'b0, 1'b1, 2'(s));
    // full rate, every divide ratio
    for (int s = 3; s >= 0; s--)
      for (int i = 0; i < 70; i++) cyc(1'b0, 1'b0, 2'(s));
    // configuration changes mid-period
    for (int k = 0; k < 12; k++)
      for (int i = 0; i < 3 + 5 * k; i++) cyc(1'b0, k[0], 2'(k % 4));
    // reset in mid-run, then recovery
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 2'b11);
    for (int i = 0; i < 80; i++) cyc(1'b0, 1'b1, 2'b11);
    for (int i = 0; i < 2; i++) cyc(1'b0, 1'b1, 2'b11);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule